// File: doc/BRIEF.md
# RTC / CMOS RAM Index-Port Decoder

This block sits on a small I/O bus and turns a two-port access scheme into the control signals of a real-time clock and a 2 KB battery-backed RAM. Software first writes an index byte to the index port. Its low six bits are an offset and one further bit picks the device that later data-port accesses reach. Each access to the data port then produces a one-cycle strobe to exactly one device: the clock's data strobe or the RAM's chip-select.

The RAM address is eleven bits wide. Its six low bits are the latched offset. Its five high bits come from a separate bank latch that software loads through a third port. When the clock is the selected device, writing the index also gives the clock an address-strobe pulse, with the offset presented on a dedicated output. All strobes are registered and appear in the cycle after the bus access that causes them. The clock and RAM cores themselves are outside this block.

Top module: `cmos_rtc_index_dec`

## Requirements
- R1: While reset is held, and after it is released until the first bus access, the outputs are: ram_addr = 0, ram_cs_n = 1, rtc_cs_n = 1, rtc_as = 0, rtc_ds = 0, rtc_rw = 1 and rtc_addr = 0.
- R2: A write to the index port (default 0x070) stores io_wdata[5:0] as the offset and io_wdata[6] as the device select (0 = clock, 1 = RAM). io_wdata[7] is ignored. The stored offset appears on rtc_addr in the next cycle.
- R3: ram_addr equals the bank latch in bits 10:6 and the offset in bits 5:0. It follows each latch update in the cycle after the write.
- R4: A write to the bank port (default 0x072) loads io_wdata[4:0] into the bank latch. io_wdata[7:5] is ignored. The bank latch keeps its value at all other times.
- R5: An index write with io_wdata[6] = 0 gives rtc_as = 1 and rtc_cs_n = 0 for exactly the next cycle. An index write with io_wdata[6] = 1 gives no address strobe.
- R6: With the device select at 0, an access to the data port (default 0x071) gives rtc_ds = 1 and rtc_cs_n = 0 for the next cycle. In that cycle rtc_rw = 1 for a read and 0 for a write, and ram_cs_n stays 1. Whenever rtc_ds is 0, rtc_rw is 1.
- R7: With the device select at 1, a data-port access gives ram_cs_n = 0 for the next cycle, while rtc_ds stays 0 and rtc_cs_n stays 1. The two chip-selects are never low together.
- R8: Accesses to any other address, and reads of the index or bank port, change no latch and produce no strobe.
- R9: If read and write are both asserted on a data-port access, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | I/O address of the current bus cycle |
| io_wr | input | 1 | Write qualifier, one cycle per access |
| io_rd | input | 1 | Read qualifier, one cycle per access |
| io_wdata | input | 8 | Write data |
| ram_addr | output | 11 | CMOS RAM address: bank and offset |
| ram_cs_n | output | 1 | CMOS RAM chip-select, active low |
| rtc_addr | output | 6 | Offset presented to the clock during the address strobe |
| rtc_as | output | 1 | Clock address strobe, active high |
| rtc_ds | output | 1 | Clock data strobe, active high |
| rtc_rw | output | 1 | Clock direction: 1 read, 0 write |
| rtc_cs_n | output | 1 | Clock chip-select, active low |

## Verification
A wrong offset or bank value is visible on ram_addr in the cycle after the bad write, because the address is formed directly from the latches. A wrong device select stays hidden until the next data-port access. At that point the strobe goes to the wrong chip-select one cycle after the access. For that reason the stimulus follows every select change with data-port reads and writes. The reference model is compared against every output on every cycle, so a stray or stretched strobe is caught in the cycle it appears.

// File: rtl/cmos_idx_pkg.sv
package cmos_idx_pkg;

  typedef enum logic {
    TGT_RTC = 1'b0,
    TGT_RAM = 1'b1
  } tgt_e;

  typedef struct packed {
    logic idx_wr;   // write to index port
    logic bank_wr;  // write to bank port
    logic dat_acc;  // read or write to data port
    logic dat_rd;   // data access is a read (write wins on collision)
  } bus_req_t;

endpackage

// File: rtl/cmos_rst_sync.sv
module cmos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain[STAGES-1];
endmodule

// File: rtl/cmos_port_decode.sv
module cmos_port_decode
  import cmos_idx_pkg::*;
#(
  parameter int          IO_AW     = 10,
  parameter logic [9:0]  IDX_PORT  = 10'h070,
  parameter logic [9:0]  DAT_PORT  = 10'h071,
  parameter logic [9:0]  BANK_PORT = 10'h072
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  output bus_req_t         req
);
  logic hit_idx, hit_dat, hit_bank;

  always_comb begin
    hit_idx  = (io_addr == IO_AW'(IDX_PORT));
    hit_dat  = (io_addr == IO_AW'(DAT_PORT));
    hit_bank = (io_addr == IO_AW'(BANK_PORT));
    req.idx_wr  = io_wr & hit_idx;
    req.bank_wr = io_wr & hit_bank;
    req.dat_acc = (io_wr | io_rd) & hit_dat;
    req.dat_rd  = io_rd & ~io_wr;
  end
endmodule

// File: rtl/cmos_index_regs.sv
module cmos_index_regs
  import cmos_idx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int OFS_W   = 6,
  parameter int BANK_W  = 5,
  parameter int SEL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  bus_req_t          req,
  input  logic [DW-1:0]     wdata,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [BANK_W-1:0] bank_q,
  output tgt_e              sel_q
);
  logic [OFS_W-1:0]  ofs_d;
  logic [BANK_W-1:0] bank_d;
  tgt_e              sel_d;
  logic              idx_en, bank_en;

  always_comb begin
    idx_en  = req.idx_wr;
    bank_en = req.bank_wr;
    ofs_d   = wdata[OFS_W-1:0];
    sel_d   = tgt_e'(wdata[SEL_BIT]);
    bank_d  = wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ofs_q <= '0;
      sel_q <= TGT_RTC;
    end else if (idx_en) begin
      ofs_q <= ofs_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  // The bank latch only moves on a bank-port write.
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req.bank_wr |=> $stable(bank_q));

  // The offset and select only move on an index-port write.
  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req.idx_wr |=> ($stable(ofs_q) && $stable(sel_q)));
endmodule

// File: rtl/cmos_strobe_gen.sv
module cmos_strobe_gen
  import cmos_idx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_q_n,
  input  bus_req_t req,
  input  logic     new_sel,
  input  tgt_e     sel_q,
  output logic     rtc_as,
  output logic     rtc_ds,
  output logic     rtc_rw,
  output logic     rtc_cs_n,
  output logic     ram_cs_n
);
  logic as_d, ds_d, rw_d, ram_d;

  always_comb begin
    as_d  = req.idx_wr & (new_sel == TGT_RTC);
    ds_d  = req.dat_acc & (sel_q == TGT_RTC);
    ram_d = req.dat_acc & (sel_q == TGT_RAM);
    rw_d  = ds_d ? req.dat_rd : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rtc_as   <= 1'b0;
      rtc_ds   <= 1'b0;
      rtc_rw   <= 1'b1;
      rtc_cs_n <= 1'b1;
      ram_cs_n <= 1'b1;
    end else begin
      rtc_as   <= as_d;
      rtc_ds   <= ds_d;
      rtc_rw   <= rw_d;
      rtc_cs_n <= ~(as_d | ds_d);
      ram_cs_n <= ~ram_d;
    end
  end

  assert_as_selects_rtc_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    rtc_as |-> !rtc_cs_n);

  assert_ds_selects_rtc_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    rtc_ds |-> (!rtc_cs_n && ram_cs_n));

  assert_rw_idle_read_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rtc_ds |-> rtc_rw);

  assert_cs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ram_cs_n |-> (rtc_cs_n && !rtc_ds && !rtc_as));

  assert_ram_needs_access_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ram_cs_n |-> $past(req.dat_acc));
endmodule

// File: rtl/cmos_rtc_index_dec.sv
module cmos_rtc_index_dec
  import cmos_idx_pkg::*;
#(
  parameter int          IO_AW       = 10,
  parameter int          DW          = 8,
  parameter int          OFS_W       = 6,
  parameter int          BANK_W      = 5,
  parameter int          SEL_BIT     = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [9:0]  IDX_PORT    = 10'h070,
  parameter logic [9:0]  DAT_PORT    = 10'h071,
  parameter logic [9:0]  BANK_PORT   = 10'h072,
  localparam int         RAM_AW      = OFS_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     io_wdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic [OFS_W-1:0]  rtc_addr,
  output logic              rtc_as,
  output logic              rtc_ds,
  output logic              rtc_rw,
  output logic              rtc_cs_n
);
  logic              rst_q_n;
  bus_req_t          req;
  logic [OFS_W-1:0]  ofs_q;
  logic [BANK_W-1:0] bank_q;
  tgt_e              sel_q;

  cmos_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cmos_port_decode #(
    .IO_AW(IO_AW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .BANK_PORT(BANK_PORT)
  ) u_dec (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .req     (req)
  );

  cmos_index_regs #(
    .DW(DW), .OFS_W(OFS_W), .BANK_W(BANK_W), .SEL_BIT(SEL_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .req     (req),
    .wdata   (io_wdata),
    .ofs_q   (ofs_q),
    .bank_q  (bank_q),
    .sel_q   (sel_q)
  );

  cmos_strobe_gen u_strb (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .req      (req),
    .new_sel  (io_wdata[SEL_BIT]),
    .sel_q    (sel_q),
    .rtc_as   (rtc_as),
    .rtc_ds   (rtc_ds),
    .rtc_rw   (rtc_rw),
    .rtc_cs_n (rtc_cs_n),
    .ram_cs_n (ram_cs_n)
  );

  assign ram_addr = {bank_q, ofs_q};
  assign rtc_addr = ofs_q;

  // A data-port access reaches some device in the following cycle.
  assert_access_strobes_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    req.dat_acc |=> (rtc_ds || !ram_cs_n));
endmodule

// File: tb/tb_cmos_rtc_index_dec.sv
module tb_cmos_rtc_index_dec;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] io_addr;
  logic       io_wr, io_rd;
  logic [7:0] io_wdata;
  logic [10:0] ram_addr;
  logic       ram_cs_n, rtc_as, rtc_ds, rtc_rw, rtc_cs_n;
  logic [5:0] rtc_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmos_rtc_index_dec dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
    .rtc_addr(rtc_addr), .rtc_as(rtc_as), .rtc_ds(rtc_ds), .rtc_rw(rtc_rw),
    .rtc_cs_n(rtc_cs_n)
  );

  // Behavioural reference state
  int m_ofs, m_bank, m_sel;
  int m_as, m_ds, m_rw, m_rcs_n, m_mcs_n;
  int compared = 0, mismatched = 0, cycles = 0;
  bit running = 1'b1;
  string phase = "R1 reset";

  always @(posedge clk) begin
    int a, w, r, d, acc;
    a = int'(io_addr); w = int'(io_wr); r = int'(io_rd); d = int'(io_wdata);
    if (!rst_n) begin
      m_ofs = 0; m_bank = 0; m_sel = 0;
      m_as = 0; m_ds = 0; m_rw = 1; m_rcs_n = 1; m_mcs_n = 1;
    end else begin
      acc   = (a == 'h71) && (w || r);
      m_as  = (w && a == 'h70 && ((d / 64) % 2) == 0) ? 1 : 0;
      m_ds  = (acc && m_sel == 0) ? 1 : 0;
      m_mcs_n = (acc && m_sel == 1) ? 0 : 1;
      m_rw  = m_ds ? (w ? 0 : 1) : 1;
      m_rcs_n = (m_as || m_ds) ? 0 : 1;
      if (w && a == 'h70) begin m_ofs = d % 64; m_sel = (d / 64) % 2; end
      if (w && a == 'h72) m_bank = d % 32;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at t=%0t", req, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R3 ram_addr", int'(ram_addr), m_bank * 64 + m_ofs);
      chk("R2 rtc_addr", int'(rtc_addr), m_ofs);
      chk("R5 rtc_as",   int'(rtc_as), m_as);
      chk("R6 rtc_ds",   int'(rtc_ds), m_ds);
      chk("R6 rtc_rw",   int'(rtc_rw), m_rw);
      chk("R6 rtc_cs_n", int'(rtc_cs_n), m_rcs_n);
      chk("R7 ram_cs_n", int'(ram_cs_n), m_mcs_n);
    end
  end

  task automatic finish_run();
    running = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic cyc(input bit w, input bit r, input int a, input int d);
    @(negedge clk);
    io_wr = w; io_rd = r; io_addr = 10'(a); io_wdata = 8'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 'h000, 0);
  endtask

  initial begin
    rst_n = 1'b0; io_wr = 0; io_rd = 0; io_addr = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);                                  // R1: quiet outputs after release

    phase = "R2 R5 index write, clock selected";
    cyc(1, 0, 'h70, 'h95); idle(2);           // bit7 set, bit6=0: offset 0x15, AS pulse
    phase = "R4 bank write";
    cyc(1, 0, 'h72, 'hF3); idle(2);           // upper bits ignored, bank=0x13
    phase = "R6 clock data read/write";
    cyc(0, 1, 'h71, 0); idle(1);
    cyc(1, 0, 'h71, 'h5A); idle(1);
    cyc(0, 1, 'h71, 0); cyc(1, 0, 'h71, 'h11); idle(2);
    phase = "R9 read and write together";
    cyc(1, 1, 'h71, 'h22); idle(2);
    phase = "R5 R7 RAM selected";
    cyc(1, 0, 'h70, 'h7F); idle(1);           // no AS, sel=RAM, offset 0x3F
    cyc(0, 1, 'h71, 0); cyc(1, 0, 'h71, 0); idle(1);
    cyc(1, 1, 'h71, 0); idle(1);
    phase = "R3 bank sweep";
    for (int b = 0; b < 32; b += 7) begin
      cyc(1, 0, 'h72, b); cyc(1, 0, 'h70, 'h40 | (b * 3 % 64)); cyc(0, 1, 'h71, 0);
    end
    idle(2);
    phase = "R8 foreign and read-only accesses";
    cyc(1, 0, 'h170, 'h00); cyc(1, 0, 'h073, 'h1F); cyc(0, 1, 'h70, 0);
    cyc(0, 1, 'h72, 0); cyc(1, 0, 'h171, 0); cyc(0, 1, 'h271, 0); idle(2);
    phase = "R5 back-to-back index writes";
    cyc(1, 0, 'h70, 'h01); cyc(1, 0, 'h70, 'h02); cyc(0, 1, 'h71, 0);
    cyc(1, 0, 'h70, 'h43); cyc(1, 0, 'h71, 0); idle(2);
    phase = "R1 reset mid-run";
    @(negedge clk); rst_n = 1'b0; io_wr = 0; io_rd = 0;
    idle(2); rst_n = 1'b1; idle(5);
    finish_run();
  end
endmodule